// File: doc/BRIEF.md
# Constant On-Time Buck Switch Sequencer

This block is the digital sequencing core of a hysteretic synchronous buck converter with a fixed on-time. It has no clock-driven modulator. A high-side pulse begins only when the output has sagged below its reference, the minimum off interval has run out, and the inductor current is not above its limit. Once a turn-on request is accepted, it is held in a latch. The pulse then runs for a programmed number of clock cycles, whatever the feedback comparator does meanwhile.

All power-stage sensing arrives as single-bit comparator results. The block returns the two gate enables. Break-before-make between the two switches is adaptive. The low side waits for the switch node to fall, and the high side waits for the low-side gate to discharge.

A mode input selects between two behaviours for the off interval:
- Light-load mode: the low side drops out at the zero-current crossing.
- Reference-transition mode: zero-cross is ignored. A negative current-limit trip instead blanks the low side for one on-time.

A force-off input, driven by external fault logic, overrides all other behaviour.

Top module: `cot_buck_seq`

## Requirements
- R1: During and after reset, with no stimulus, the high-side enable is 0 and the low-side enable is 1.
- R2: A turn-on is accepted only on a cycle where feedback-low is 1, positive-limit is 0 and the minimum off interval has expired. While positive-limit is held at 1, no pulse starts. After acceptance, the high side rises two clock edges later, provided the low-gate-discharged input is 1.
- R3: Once accepted, the high-side pulse lasts exactly the on-time count sampled at its start, even if feedback-low returns to 0 during the pulse.
- R4: An on-time count below TON_MIN (default 4) is raised to TON_MIN.
- R5: After the high side falls, the next acceptance is evaluated no earlier than TOFF_CYC (default 50) cycles later. With feedback held low and both interlock inputs at 1, the high side stays low for exactly TOFF_CYC+2 cycles between pulses.
- R6: After a high-side pulse, the low side turns on only on the edge after the switch-node-low input is sampled at 1.
- R7: After acceptance, the high side turns on only on the edge after the low-gate-discharged input is sampled at 1. Until then, both enables are 0.
- R8: With mode 0 (light load), a zero-cross input of 1 while the low side conducts turns the low side off on the next edge. It stays off until the next accepted turn-on. With mode 1, zero-cross has no effect.
- R9: With mode 1, a negative-limit input of 1 while the low side conducts turns both switches off for exactly the clamped on-time count. After that, the high-side sequence starts if a turn-on is acceptable. Otherwise the low side turns back on.
- R10: While force-off is 1, from the next edge onward the high side is 0 and the low side is 1. The high side's exit from a pulse by this path still starts the minimum off interval.
- R11: When a turn-on is acceptable on the same cycle that zero-cross (mode 0) or negative-limit (mode 1) fires, the turn-on wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fb_low_i | input | 1 | Feedback is below reference |
| ilim_pos_i | input | 1 | Positive (valley) current limit asserted |
| ilim_neg_i | input | 1 | Negative current limit asserted |
| zero_cross_i | input | 1 | Inductor current has reached zero |
| phase_low_i | input | 1 | Switch node below the low-side enable threshold |
| lgate_low_i | input | 1 | Low-side gate below the high-side enable threshold |
| ton_cycles_i | input | TON_W | Programmed on-time in clock cycles |
| trans_mode_i | input | 1 | 0: light-load zero-cross mode, 1: reference-transition mode |
| force_off_i | input | 1 | Fault override: high side off, low side on |
| hs_on_o | output | 1 | High-side gate enable |
| ls_on_o | output | 1 | Low-side gate enable |

## Verification
The sharp case is a turn-on becoming acceptable on the very cycle that zero-cross or the negative limit fires while the low side conducts. Both events pull the low side off on the next edge, so the low-side output alone cannot show which one won. The bench therefore raises feedback-low together with the competing comparator for a single cycle and then drops it. If the turn-on won, a high-side pulse follows two edges later. If the competitor won, the block parks with both switches off, or enters the blanking interval, and no pulse appears. A behavioural reference model running every cycle judges the same distinction throughout all other phases.

// File: rtl/cot_pkg.sv
package cot_pkg;
  typedef enum logic [2:0] {
    ST_LS_ON,
    ST_IDLE,
    ST_DT_HS,
    ST_HS_ON,
    ST_DT_LS,
    ST_HOLD,
    ST_FORCE
  } cot_state_e;
endpackage

// File: rtl/cot_down_timer.sv
module cot_down_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cot_seq_fsm.sv
module cot_seq_fsm
  import cot_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fb_low_i,
  input  logic ilim_pos_i,
  input  logic ilim_neg_i,
  input  logic zero_cross_i,
  input  logic phase_low_i,
  input  logic lgate_low_i,
  input  logic trans_mode_i,
  input  logic force_off_i,
  input  logic off_zero_i,
  input  logic pulse_last_i,
  output logic pulse_load_o,
  output logic off_load_o,
  output logic hs_on_o,
  output logic ls_on_o
);
  cot_state_e state_q, state_d;
  logic start;

  assign start = fb_low_i & off_zero_i & ~ilim_pos_i;

  always_comb begin
    state_d      = state_q;
    pulse_load_o = 1'b0;
    if (force_off_i) begin
      state_d = ST_FORCE;
    end else begin
      unique case (state_q)
        ST_LS_ON: begin
          if (start) state_d = ST_DT_HS;
          else if (trans_mode_i && ilim_neg_i) begin
            state_d      = ST_HOLD;
            pulse_load_o = 1'b1;
          end else if (!trans_mode_i && zero_cross_i) state_d = ST_IDLE;
        end
        ST_IDLE:  if (start) state_d = ST_DT_HS;
        ST_DT_HS: if (lgate_low_i) begin
          state_d      = ST_HS_ON;
          pulse_load_o = 1'b1;
        end
        ST_HS_ON: if (pulse_last_i) state_d = ST_DT_LS;
        ST_DT_LS: if (phase_low_i) state_d = ST_LS_ON;
        ST_HOLD:  if (pulse_last_i) state_d = start ? ST_DT_HS : ST_LS_ON;
        ST_FORCE: state_d = ST_LS_ON;
        default:  state_d = ST_LS_ON;
      endcase
    end
  end

  assign off_load_o = (state_q == ST_HS_ON) && (state_d != ST_HS_ON);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_LS_ON;
    else         state_q <= state_d;
  end

  assign hs_on_o = (state_q == ST_HS_ON);
  assign ls_on_o = (state_q == ST_LS_ON) || (state_q == ST_FORCE);

  p_hs_after_lgate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_on_o) |-> $past(lgate_low_i));

  p_ls_after_phase_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ls_on_o) && $past(state_q) == ST_DT_LS) |-> $past(phase_low_i));

  p_no_start_fb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_LS_ON || state_q == ST_IDLE) && (!fb_low_i || ilim_pos_i))
      |=> state_q != ST_DT_HS);

  p_force_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_off_i |=> (!hs_on_o && ls_on_o));
endmodule

// File: rtl/cot_buck_seq.sv
module cot_buck_seq #(
  parameter int TON_W    = 8,
  parameter int TON_MIN  = 4,
  parameter int TOFF_CYC = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fb_low_i,
  input  logic             ilim_pos_i,
  input  logic             ilim_neg_i,
  input  logic             zero_cross_i,
  input  logic             phase_low_i,
  input  logic             lgate_low_i,
  input  logic [TON_W-1:0] ton_cycles_i,
  input  logic             trans_mode_i,
  input  logic             force_off_i,
  output logic             hs_on_o,
  output logic             ls_on_o
);
  localparam int OFF_W = $clog2(TOFF_CYC + 1);

  logic [TON_W-1:0] ton_eff, pulse_cnt;
  logic [OFF_W-1:0] off_cnt;
  logic pulse_load, off_load, off_zero, pulse_last;

  // Clamp keeps the one-shot from degenerating below TON_MIN cycles
  assign ton_eff    = (ton_cycles_i < TON_W'(TON_MIN)) ? TON_W'(TON_MIN) : ton_cycles_i;
  assign off_zero   = (off_cnt == '0);
  assign pulse_last = (pulse_cnt == TON_W'(1));

  cot_down_timer #(.W(TON_W)) u_pulse_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (pulse_load),
    .val_i  (ton_eff),
    .cnt_o  (pulse_cnt)
  );

  cot_down_timer #(.W(OFF_W)) u_off_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (off_load),
    .val_i  (OFF_W'(TOFF_CYC)),
    .cnt_o  (off_cnt)
  );

  cot_seq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fb_low_i     (fb_low_i),
    .ilim_pos_i   (ilim_pos_i),
    .ilim_neg_i   (ilim_neg_i),
    .zero_cross_i (zero_cross_i),
    .phase_low_i  (phase_low_i),
    .lgate_low_i  (lgate_low_i),
    .trans_mode_i (trans_mode_i),
    .force_off_i  (force_off_i),
    .off_zero_i   (off_zero),
    .pulse_last_i (pulse_last),
    .pulse_load_o (pulse_load),
    .off_load_o   (off_load),
    .hs_on_o      (hs_on_o),
    .ls_on_o      (ls_on_o)
  );

  p_min_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_on_o) |-> $past(off_zero));

  p_pulse_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(hs_on_o) && !$past(force_off_i)) |-> $past(pulse_last));

  p_off_armed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_on_o) |-> (off_cnt == OFF_W'(TOFF_CYC)));
endmodule

// File: tb/sim_cot_buck_seq.sv
module sim_cot_buck_seq;
  localparam int TON_W = 8, TON_MIN = 4, TOFF = 50;
  localparam int M_LS = 0, M_IDLE = 1, M_DTH = 2, M_HS = 3, M_DTL = 4, M_HOLD = 5, M_FRC = 6;

  logic clk = 0, rst_n = 0;
  logic fb = 0, ilp = 0, iln = 0, zc = 0, phl = 1, lgl = 1, trans = 0, frc = 0;
  logic [TON_W-1:0] ton = 8'd10;
  logic hs, ls;
  int checks = 0, fails = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  cot_buck_seq #(.TON_W(TON_W), .TON_MIN(TON_MIN), .TOFF_CYC(TOFF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .fb_low_i(fb), .ilim_pos_i(ilp), .ilim_neg_i(iln),
    .zero_cross_i(zc), .phase_low_i(phl), .lgate_low_i(lgl), .ton_cycles_i(ton),
    .trans_mode_i(trans), .force_off_i(frc), .hs_on_o(hs), .ls_on_o(ls));

  // Behavioural reference model
  int ms, on_left, off_left;
  always @(posedge clk or negedge rst_n) begin
    int nxt, clamp;
    bit st;
    if (!rst_n) begin
      ms = M_LS; on_left = 0; off_left = 0;
    end else begin
      st = fb && off_left == 0 && !ilp;
      clamp = (int'(ton) < TON_MIN) ? TON_MIN : int'(ton);
      nxt = ms;
      if (frc) nxt = M_FRC;
      else if (ms == M_LS) begin
        if (st) nxt = M_DTH;
        else if (trans && iln) begin nxt = M_HOLD; on_left = clamp + 1; end
        else if (!trans && zc) nxt = M_IDLE;
      end else if (ms == M_IDLE) begin if (st) nxt = M_DTH; end
      else if (ms == M_DTH) begin if (lgl) begin nxt = M_HS; on_left = clamp + 1; end end
      else if (ms == M_HS) begin if (on_left == 1) nxt = M_DTL; end
      else if (ms == M_DTL) begin if (phl) nxt = M_LS; end
      else if (ms == M_HOLD) begin if (on_left == 1) nxt = st ? M_DTH : M_LS; end
      else if (ms == M_FRC) nxt = M_LS;
      if (ms == M_HS && nxt != M_HS) off_left = TOFF;
      else if (off_left > 0) off_left--;
      if (on_left > 0) on_left--;
      ms = nxt;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (hs !== (ms == M_HS) || ls !== (ms == M_LS || ms == M_FRC)) begin
        fails++;
        $display("FAIL %s lockstep actual hs=%b ls=%b expected hs=%b ls=%b",
                 cur_req, hs, ls, ms == M_HS, ms == M_LS || ms == M_FRC);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string rq, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    while (!hs && n < 500) begin step(1); n++; end
  endtask

  task automatic width(output int n);
    n = 0;
    while (hs && n < 500) begin step(1); n++; end
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog actual=timeout expected=done");
    report();
  end

  initial begin
    int n;
    step(3);
    chk("R1 hs in reset", int'(hs), 0);
    chk("R1 ls in reset", int'(ls), 1);
    rst_n = 1;
    step(60);
    cur_req = "R2";
    chk("R2 idle feedback high", int'(hs), 0);
    fb = 1; ilp = 1;
    step(10);
    chk("R2 blocked by positive limit", int'(hs), 0);
    ilp = 0;
    wait_rise(n);
    chk("R2 start latency", n, 2);
    cur_req = "R3";
    fb = 0;
    width(n);
    chk("R3 latched width", n, 10);
    cur_req = "R5";
    fb = 1; ton = 8'd1;
    n = 0;
    while (!hs && n < 500) begin step(1); n++; end
    chk("R5 min off gap", n, TOFF + 2);
    cur_req = "R4";
    fb = 0;
    width(n);
    chk("R4 clamped width", n, TON_MIN);
    step(60);
    cur_req = "R6";
    ton = 8'd8; phl = 0; fb = 1;
    wait_rise(n);
    fb = 0;
    width(n);
    step(5);
    chk("R6 ls waits for switch node", int'(ls), 0);
    phl = 1;
    step(1);
    chk("R6 ls after switch node low", int'(ls), 1);
    step(60);
    cur_req = "R7";
    lgl = 0; fb = 1;
    step(5);
    chk("R7 hs waits for low gate", int'(hs), 0);
    lgl = 1; fb = 0;
    step(1);
    chk("R7 hs after low gate", int'(hs), 1);
    step(70);
    cur_req = "R8";
    trans = 0; zc = 1;
    step(1);
    chk("R8 zero cross drops ls", int'(ls), 0);
    zc = 0;
    step(5);
    chk("R8 ls stays off", int'(ls), 0);
    fb = 1;
    wait_rise(n);
    fb = 0;
    step(70);
    trans = 1; zc = 1;
    step(3);
    chk("R8 zero cross ignored in transition", int'(ls), 1);
    zc = 0;
    cur_req = "R9";
    ton = 8'd6; iln = 1;
    step(1);
    iln = 0;
    n = 0;
    while (!ls && n < 500) begin step(1); n++; end
    chk("R9 hold length", n, 6);
    iln = 1;
    step(1);
    iln = 0; fb = 1;
    wait_rise(n);
    chk("R9 start after hold", n, 7);
    fb = 0;
    step(70);
    cur_req = "R11";
    trans = 0; fb = 1; zc = 1;
    step(1);
    fb = 0; zc = 0;
    step(1);
    chk("R11 start beats zero cross", int'(hs), 1);
    step(70);
    trans = 1; fb = 1; iln = 1;
    step(1);
    fb = 0; iln = 0;
    step(1);
    chk("R11 start beats negative limit", int'(hs), 1);
    step(70);
    cur_req = "R10";
    ton = 8'd20; fb = 1;
    wait_rise(n);
    step(3);
    frc = 1;
    step(1);
    chk("R10 force hs", int'(hs), 0);
    chk("R10 force ls", int'(ls), 1);
    step(5);
    chk("R10 force held", int'(ls), 1);
    frc = 0; fb = 0;
    step(70);
    report();
  end
endmodule